// File: doc/BRIEF.md
# Key-Protected Interrupt Level Filter

This block decides, for one pending interrupt at a time, whether the processor should take it. It owns a 32-bit software-visible register whose only live field is a 4-bit user mask level. Software may lower or raise that level at run time. A write lands only if it carries a fixed key byte in its top eight bits, so a stray or corrupted store cannot open or close the interrupt window by accident.

A candidate interrupt is accepted only when three conditions all hold. Its priority must be strictly above the user mask level. Its own per-source disable bit must be clear. Its priority must also be strictly above the processor status mask level. A non-maskable interrupt skips every condition. The accept output is combinational from the stored level and the present inputs. Arbitration among several sources and vector generation are done elsewhere.

Top module: `irq_level_gate`

## Requirements
- R1: Reads (`reg_sel`=1, `reg_we`=0) return the user mask level in bits 7:4 and zero in every other bit. `reg_rdata` is all zero while `reg_sel`=0 or `reg_we`=1. Bits outside 7:4 cannot be stored.
- R2: A write (`reg_sel`=1, `reg_we`=1) updates the level from `reg_wdata[7:4]` at the next rising clock edge only when `reg_wdata[31:24]` equals 0xA5. Any other key value leaves the level unchanged. A key-bearing value presented with `reg_sel`=0 also leaves it unchanged.
- R3: After reset (`rst_n` low, asynchronous) the register reads 0x00000000.
- R4: With `irq_valid`=1 and `irq_nmi`=0, an interrupt whose priority is less than or equal to the user mask level is not accepted.
- R5: With the user mask level at 0xF, `irq_accept` is 0 for every input combination with `irq_nmi`=0.
- R6: With `irq_nmi`=0, an interrupt whose `irq_disable` bit is 1 is not accepted.
- R7: With `irq_nmi`=0, an interrupt is accepted only if its priority is strictly greater than `sr_mask`.
- R8: `irq_nmi`=1 forces `irq_accept`=1, whatever the other inputs and the level are.
- R9: Accepting interrupts never changes the stored user mask level.
- R10: `irq_accept` = `irq_nmi` OR (`irq_valid` AND NOT `irq_disable` AND priority > level AND priority > `sr_mask`), using the level stored at the time. A write in the same cycle affects acceptance only after the clock edge that stores it.
- R11: With `irq_valid`=0 and `irq_nmi`=0, `irq_accept` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select |
| reg_we | input | 1 | Write enable, qualified by `reg_sel` |
| reg_wdata | input | 32 | Write data: key in 31:24, level in 7:4 |
| reg_rdata | output | 32 | Read data |
| irq_valid | input | 1 | A maskable interrupt is pending |
| irq_prio | input | 4 | Priority of the pending interrupt |
| irq_nmi | input | 1 | Non-maskable interrupt present |
| irq_disable | input | 1 | Per-source mask bit, 1 = disabled |
| sr_mask | input | 4 | Processor status mask level |
| irq_accept | output | 1 | Interrupt accepted |

## Verification
A keyed register write and an acceptance decision can fall in the same cycle. The decision must then use the level stored before the edge, and the new level must govern only after it. The bench provokes this by holding an interrupt pending while it writes a level that would mask that interrupt. It samples `irq_accept` just before the edge, expecting acceptance, and again just after, expecting masking. Over many cycles it also keeps accepted interrupts pending and reads the level back to confirm that acceptance never changes it.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    parameter int DATA_W  = 32;
    parameter int LVL_W   = 4;
    parameter int LVL_LSB = 4;
    parameter int KEY_W   = 8;
    parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5;
    localparam int KEY_LSB = DATA_W - KEY_W;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
    } lvl_state_t;
endpackage

// File: rtl/irq_gate_lvl_reg.sv
module irq_gate_lvl_reg
    import irq_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  lvl_o
);
    lvl_state_t st_d, st_q;
    logic       key_ok;
    logic       wr_go;

    // Bits outside the key and level fields are discarded by design.
    logic unused_wbits;
    assign unused_wbits = ^{wdata[KEY_LSB-1:LVL_LSB+LVL_W], wdata[LVL_LSB-1:0]};

    always_comb begin
        key_ok = (wdata[KEY_LSB +: KEY_W] == KEY_VAL);
        wr_go  = sel && we && key_ok;
        st_d   = st_q;
        if (wr_go) begin
            st_d.lvl = wdata[LVL_LSB +: LVL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !we) begin
            rdata[LVL_LSB +: LVL_W] = st_q.lvl;
        end
    end

    assign lvl_o = st_q.lvl;

    assert_keyless_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sel && we && wdata[KEY_LSB +: KEY_W] == KEY_VAL)) |=> $stable(lvl_o));

    assert_keyed_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && wdata[KEY_LSB +: KEY_W] == KEY_VAL)
        |=> (lvl_o == $past(wdata[LVL_LSB +: LVL_W])));
endmodule

// File: rtl/irq_gate_accept.sv
module irq_gate_accept
    import irq_gate_pkg::*;
#(
    parameter int NUM_THR = 2
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          nmi,
    input  logic                          valid,
    input  logic                          dis,
    input  logic [LVL_W-1:0]              prio,
    input  logic [NUM_THR-1:0][LVL_W-1:0] thr,
    output logic                          accept
);
    logic [NUM_THR-1:0] above;

    generate
        for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_thr
            assign above[gi] = (prio > thr[gi]);
        end
    endgenerate

    always_comb begin
        accept = nmi || (valid && !dis && (&above));
    end

    assert_nmi_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> accept);

    assert_full_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi && thr[0] == '1) |-> !accept);

    assert_src_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi && dis) |-> !accept);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi && !valid) |-> !accept);
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_valid,
    input  logic [LVL_W-1:0]  irq_prio,
    input  logic              irq_nmi,
    input  logic              irq_disable,
    input  logic [LVL_W-1:0]  sr_mask,
    output logic              irq_accept
);
    localparam int NUM_THR = 2;
    localparam logic [DATA_W-1:0] FIELD_MASK = {{(DATA_W-LVL_W){1'b0}}, {LVL_W{1'b1}}} << LVL_LSB;

    logic [LVL_W-1:0]              user_lvl;
    logic [NUM_THR-1:0][LVL_W-1:0] thr_vec;

    irq_gate_lvl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (reg_sel),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .lvl_o (user_lvl)
    );

    always_comb begin
        thr_vec[0] = user_lvl;
        thr_vec[1] = sr_mask;
    end

    irq_gate_accept #(.NUM_THR(NUM_THR)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi    (irq_nmi),
        .valid  (irq_valid),
        .dis    (irq_disable),
        .prio   (irq_prio),
        .thr    (thr_vec),
        .accept (irq_accept)
    );

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~FIELD_MASK) == '0);

    assert_accept_keeps_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && !(reg_sel && reg_we)) |=> $stable(user_lvl));
endmodule

// File: tb/sim_irq_level_gate.sv
`timescale 1ns/10ps
module sim_irq_level_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_valid = 1'b0, irq_nmi = 1'b0, irq_disable = 1'b0;
    logic [3:0]  irq_prio = '0, sr_mask = '0;
    logic        irq_accept;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_level_gate u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_prio(irq_prio), .irq_nmi(irq_nmi), .irq_disable(irq_disable),
        .sr_mask(sr_mask), .irq_accept(irq_accept)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] val, input logic sel);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = val;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_check(input logic [3:0] lvl, input string tag);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0;
        #0.5;
        check(reg_rdata == {24'h0, lvl, 4'h0}, tag, reg_rdata, {24'h0, lvl, 4'h0});
        reg_sel = 1'b0;
        #0.5;
        check(reg_rdata == 32'h0, "R1 idle read", reg_rdata, 32'h0);
    endtask

    function automatic bit model(input logic [3:0] lvl, input logic [3:0] p, input logic [3:0] s,
                                 input logic v, input logic d, input logic n);
        return n || (v && !d && (p > lvl) && (p > s));
    endfunction

    task automatic sweep(input logic [3:0] lvl);
        @(negedge clk);
        for (int c = 0; c < 4096; c++) begin
            irq_prio = c[3:0]; sr_mask = c[7:4];
            irq_valid = c[8]; irq_disable = c[9]; irq_nmi = c[10];
            #0.1;
            begin
                bit e;
                string tag;
                e = model(lvl, irq_prio, sr_mask, irq_valid, irq_disable, irq_nmi);
                if (irq_nmi) tag = "R8 nmi";
                else if (!irq_valid) tag = "R11 idle";
                else if (lvl == 4'hF) tag = "R5 full mask";
                else if (irq_disable) tag = "R6 src disable";
                else if (irq_prio <= lvl) tag = "R4 level";
                else tag = "R7/R10 status mask";
                check(irq_accept == e, tag, {31'h0, irq_accept}, {31'h0, e});
            end
            #0.1;
        end
        irq_valid = 1'b0; irq_nmi = 1'b0; irq_disable = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] bad_keys [5] = '{8'h00, 8'hA4, 8'hA6, 8'h5A, 8'hFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_check(4'h0, "R3 reset value");
        sweep(4'h0);

        // R2: keyed writes with noise in other bits; R1 reserved bits not stored
        reg_write(32'hA5FF_FF3F, 1'b1);
        read_check(4'h3, "R1 R2 keyed write with noise");
        foreach (bad_keys[k]) begin
            reg_write({bad_keys[k], 24'h0000_90}, 1'b1);
            read_check(4'h3, "R2 wrong key ignored");
        end
        reg_write(32'hA500_0090, 1'b0);
        read_check(4'h3, "R2 unselected write ignored");

        // write-data visible on rdata during write: must be zero (R1)
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 32'h1200_0050;
        #0.5;
        check(reg_rdata == 32'h0, "R1 rdata during write", reg_rdata, 32'h0);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;

        // full sweep of every level
        for (int l = 0; l < 16; l++) begin
            reg_write({8'hA5, 16'h0, l[3:0], 4'h0}, 1'b1);
            read_check(l[3:0], "R2 level store");
            sweep(l[3:0]);
        end

        // R10: same-cycle write and acceptance
        reg_write(32'hA500_0020, 1'b1);
        @(negedge clk);
        irq_valid = 1'b1; irq_prio = 4'h5; sr_mask = 4'h0;
        reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 32'hA500_0070;
        #1;
        check(irq_accept == 1'b1, "R10 old level before edge", {31'h0, irq_accept}, 32'h1);
        @(posedge clk);
        #0.5;
        check(irq_accept == 1'b0, "R10 new level after edge", {31'h0, irq_accept}, 32'h0);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        irq_valid = 1'b0;
        read_check(4'h7, "R10 stored level");

        // R9: long stretch of accepted interrupts, level held
        reg_write(32'hA500_0010, 1'b1);
        @(negedge clk);
        irq_valid = 1'b1; irq_prio = 4'hE; sr_mask = 4'h2; irq_nmi = 1'b1;
        repeat (20) begin
            @(negedge clk);
            check(irq_accept == 1'b1, "R9 accepting", {31'h0, irq_accept}, 32'h1);
        end
        irq_valid = 1'b0; irq_nmi = 1'b0;
        read_check(4'h1, "R9 level unchanged after accepts");

        // R3: reset in the middle of use
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_check(4'h0, "R3 reset after use");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule